// File: doc/BRIEF.md
# Multi-Device Tuning Serial Bus Master

This block writes 8-bit state words to a group of tunable-capacitance devices over a three-wire serial bus. All devices share one serial clock. Each device has its own enable line and its own data lane. A host hands over one request at a time through a valid/ready handshake.

In per-device mode, the request names one device. Only that device's enable rises. Every data lane carries the same word, so a board that shares one data wire can tie it to any lane. In broadcast mode, all enables rise together and each lane carries its own word. Every device then takes its new state on the same falling enable edge.

A word is shifted out most significant bit first. A device latches a bit on each rising edge of the serial clock and commits the last eight bits it received when its enable falls. Every interface timing is a minimum given in picoseconds. The block converts each one to a whole number of system-clock cycles, rounding up.

Top module: `tune_bus_master`

## Requirements
- R1: After reset, every enable is low, the serial clock and every data lane are low, and `reqReady` is high.
- R2: A per-device request (`reqAll` = 0) raises only enable `reqDev`. It produces exactly eight serial-clock rising edges while that enable is high and presents `reqWord` most significant bit first. The word a device captures on those edges equals `reqWord` when its enable falls.
- R3: A device whose enable stays low during a transfer keeps the word it last committed.
- R4: A broadcast request (`reqAll` = 1) raises and drops all enables in the same cycle. Lane i carries bits `reqLanes[8*i+7 : 8*i]`, and every device commits its own lane word.
- R5: At least SETUP_CYC system cycles separate an enable rising from the first serial-clock rise (1 at the defaults).
- R6: Every serial-clock high phase and every low phase inside a transfer lasts at least HALF_CYC cycles (1 at the defaults). Rising edges are at least 2*HALF_CYC cycles apart, which is no faster than 26 MHz.
- R7: While an enable is high, a data lane changes only in the cycle in which the serial clock falls. It stays put while the clock is high.
- R8: At least HOLD_CYC cycles separate the last serial-clock rise from the enable falling (1 at the defaults).
- R9: An enable stays low for at least GAP_CYC cycles before any enable rises again (2 at the defaults).
- R10: `reqReady` goes low in the cycle after a request is accepted. It is high only when all enables are low and at least GAP_CYC cycles have passed since the last enable fell.
- R11: Whenever every enable is low, the serial clock and every data lane are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Master can accept a request |
| reqAll | input | 1 | 1 selects a broadcast to all devices |
| reqDev | input | DEV_W | Target device index in per-device mode |
| reqWord | input | 8 | Word for the target device in per-device mode |
| reqLanes | input | 8*NUM_DEV | Per-lane words in broadcast mode |
| busClk | output | 1 | Shared serial clock, idles low |
| busData | output | NUM_DEV | Serial data lanes, one per device |
| busEn | output | NUM_DEV | Enable lines, one per device |

## Verification
The bench checks every device index with words that set only the top bit, only the bottom bit, all bits and alternating bits. A design that shifted least significant bit first, sent seven or nine bits, or committed at the wrong edge would leave the device model holding a different word. The bench then checks the devices that were not selected. A decode that raised the wrong enable, or that disturbed a neighbour, would change their committed words.

Broadcast patterns give every lane a different word. Swapped lane slicing, or enables that fell in different cycles, would show up as a mismatch or as split commit cycles.

Requests are issued back to back. A master that released ready too early would shorten the enable-low gap. One that changed data while the clock was high, or raised the clock too soon after the enable, breaks the edge timing that the bench measures in system cycles.

// File: rtl/tune_bus_pkg.sv
package tune_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } busState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic clkSet;
    logic clkClr;
    logic enDrop;
  } busStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tune_bus_ctrl.sv
module tune_bus_ctrl
  import tune_bus_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int HALF_CYC  = 1,
  parameter int HOLD_CYC  = 1,
  parameter int GAP_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  output logic       reqReady,
  output busStrobe_t strb
);

  localparam int MAX_CYC = maxOf(maxOf(SETUP_CYC, HALF_CYC), maxOf(HOLD_CYC, GAP_CYC));
  localparam int TMR_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  busState_t        state, stateNxt;
  logic [TMR_W-1:0] tmr, tmrVal;
  logic             tmrLoad;
  logic [2:0]       bitCnt;
  logic             bitInc;
  logic             tmrDone;

  assign tmrDone  = (tmr == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    tmrLoad  = 1'b0;
    tmrVal   = '0;
    bitInc   = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        stateNxt  = ST_SETUP;
        tmrLoad   = 1'b1;
        tmrVal    = TMR_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (tmrDone) begin
        strb.clkSet = 1'b1;
        stateNxt    = ST_HIGH;
        tmrLoad     = 1'b1;
        tmrVal      = TMR_W'(HALF_CYC - 1);
      end
      ST_HIGH: if (tmrDone) begin
        strb.clkClr = 1'b1;
        strb.shift  = 1'b1;
        tmrLoad     = 1'b1;
        if (bitCnt == 3'd7) begin
          stateNxt = ST_HOLD;
          tmrVal   = TMR_W'(HOLD_CYC - 1);
        end else begin
          stateNxt = ST_LOW;
          tmrVal   = TMR_W'(HALF_CYC - 1);
        end
      end
      ST_LOW: if (tmrDone) begin
        strb.clkSet = 1'b1;
        bitInc      = 1'b1;
        stateNxt    = ST_HIGH;
        tmrLoad     = 1'b1;
        tmrVal      = TMR_W'(HALF_CYC - 1);
      end
      ST_HOLD: if (tmrDone) begin
        strb.enDrop = 1'b1;
        stateNxt    = ST_GAP;
        tmrLoad     = 1'b1;
        tmrVal      = TMR_W'(GAP_CYC - 1);
      end
      ST_GAP: if (tmrDone) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tmr    <= '0;
      bitCnt <= '0;
    end else begin
      state <= stateNxt;
      if (tmrLoad)       tmr <= tmrVal;
      else if (!tmrDone) tmr <= tmr - 1'b1;
      if (strb.load)     bitCnt <= '0;
      else if (bitInc)   bitCnt <= bitCnt + 1'b1;
    end
  end

  // R10: an accepted request blocks the next one
  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  // R2: eight bits end with a hold phase, never a ninth rise
  a_r2_eight_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> (bitCnt == 3'd7));

endmodule

// File: rtl/tune_bus_datapath.sv
module tune_bus_datapath
  import tune_bus_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  busStrobe_t           strb,
  input  logic                 reqAll,
  input  logic [DEV_W-1:0]     reqDev,
  input  logic [7:0]           reqWord,
  input  logic [8*NUM_DEV-1:0] reqLanes,
  output logic                 busClk,
  output logic [NUM_DEV-1:0]   busData,
  output logic [NUM_DEV-1:0]   busEn
);

  logic [NUM_DEV-1:0] selMask;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_lane
    logic [7:0] shReg;

    assign selMask[g] = reqAll || (reqDev == DEV_W'(g));
    assign busData[g] = shReg[7];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shReg <= '0;
      else if (strb.load)  shReg <= reqAll ? reqLanes[8*g +: 8] : reqWord;
      else if (strb.shift) shReg <= {shReg[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busClk <= 1'b0;
      busEn  <= '0;
    end else begin
      if (strb.clkSet)      busClk <= 1'b1;
      else if (strb.clkClr) busClk <= 1'b0;
      if (strb.load)        busEn <= selMask;
      else if (strb.enDrop) busEn <= '0;
    end
  end

  // R11: idle bus is quiet
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busEn == '0) |-> (!busClk && (busData == '0)));

  // R7: data holds while the serial clock stays high
  a_r7_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busClk && $past(busClk)) |-> $stable(busData));

  // R2, R4: one enable or all of them
  a_r4_enable_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(busEn) <= 1) || ($countones(busEn) == NUM_DEV));

  // R5: no clock rise without an enable that was already high
  a_r5_clk_after_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busClk) |-> ((busEn != '0) && ($past(busEn) != '0)));

  // R8: enable falls only with the clock low for a cycle
  a_r8_en_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((busEn == '0) && ($past(busEn) != '0)) |-> (!busClk && !$past(busClk)));

endmodule

// File: rtl/tune_bus_master.sv
module tune_bus_master
  import tune_bus_pkg::*;
#(
  parameter int NUM_DEV          = 4,
  parameter int SYS_PERIOD_PS    = 20000,
  parameter int CLK_MIN_PERIOD_PS = 38462,
  parameter int EN_SETUP_PS      = 19200,
  parameter int EN_HOLD_PS       = 19200,
  parameter int DATA_MARGIN_PS   = 13200,
  parameter int EN_GAP_PS        = 38400,
  localparam int DEV_W           = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqAll,
  input  logic [DEV_W-1:0]     reqDev,
  input  logic [7:0]           reqWord,
  input  logic [8*NUM_DEV-1:0] reqLanes,
  output logic                 busClk,
  output logic [NUM_DEV-1:0]   busData,
  output logic [NUM_DEV-1:0]   busEn
);

  localparam int HALF_CYC  = maxOf(1, maxOf(ceilDiv(CLK_MIN_PERIOD_PS, 2 * SYS_PERIOD_PS),
                                            ceilDiv(DATA_MARGIN_PS, SYS_PERIOD_PS)));
  localparam int SETUP_CYC = maxOf(1, maxOf(ceilDiv(EN_SETUP_PS, SYS_PERIOD_PS),
                                            ceilDiv(DATA_MARGIN_PS, SYS_PERIOD_PS)));
  localparam int HOLD_CYC  = maxOf(1, ceilDiv(EN_HOLD_PS, SYS_PERIOD_PS));
  localparam int GAP_CYC   = maxOf(1, ceilDiv(EN_GAP_PS, SYS_PERIOD_PS));

  busStrobe_t strb;

  tune_bus_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .HALF_CYC (HALF_CYC),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strb    (strb)
  );

  tune_bus_datapath #(
    .NUM_DEV(NUM_DEV),
    .DEV_W  (DEV_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .reqAll  (reqAll),
    .reqDev  (reqDev),
    .reqWord (reqWord),
    .reqLanes(reqLanes),
    .busClk  (busClk),
    .busData (busData),
    .busEn   (busEn)
  );

endmodule

// File: tb/tune_bus_master_bench.sv
module tune_bus_master_bench;

  localparam int N        = 4;
  localparam int SYS_PS   = 20000;
  localparam int SETUP_C  = (19200 + SYS_PS - 1) / SYS_PS;
  localparam int HOLD_C   = (19200 + SYS_PS - 1) / SYS_PS;
  localparam int GAP_C    = (38400 + SYS_PS - 1) / SYS_PS;
  localparam int PERIOD_C = (38462 + SYS_PS - 1) / SYS_PS;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reqValid = 1'b0;
  logic           reqReady;
  logic           reqAll = 1'b0;
  logic [1:0]     reqDev = '0;
  logic [7:0]     reqWord = '0;
  logic [8*N-1:0] reqLanes = '0;
  logic           busClk;
  logic [N-1:0]   busData, busEn;

  int total = 0;
  int bad = 0;

  tune_bus_master u_tune_bus_master (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqAll(reqAll), .reqDev(reqDev), .reqWord(reqWord), .reqLanes(reqLanes),
    .busClk(busClk), .busData(busData), .busEn(busEn)
  );

  always #10ns clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model and timing monitor, sampled at the falling system edge
  int         cyc = 0;
  logic [7:0] devSh[N];
  logic [7:0] devCommit[N];
  int         commitCyc[N];
  int         riseCnt[N];
  int         enRiseCyc[N];
  int         lastFallCyc = -1000;
  int         lastClkRise = -1000;
  int         clkRiseNo = 0;
  int         clkFallCyc = -1000;
  logic       prevClk = 1'b0;
  logic [N-1:0] prevEn = '0, prevData = '0;

  initial for (int i = 0; i < N; i++) begin
    devSh[i] = '0; devCommit[i] = '0; commitCyc[i] = 0; riseCnt[i] = 0; enRiseCyc[i] = 0;
  end

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (busClk && !prevClk) begin
      if (clkRiseNo > 0 && (cyc - lastClkRise) < 8)
        check(cyc - lastClkRise >= PERIOD_C, "R6 clk period", cyc - lastClkRise, PERIOD_C);
      check(cyc - clkFallCyc >= 1, "R6 low phase", cyc - clkFallCyc, 1);
      lastClkRise = cyc;
      clkRiseNo++;
    end
    if (!busClk && prevClk) begin
      check(cyc - lastClkRise >= 1, "R6 high phase", cyc - lastClkRise, 1);
      clkFallCyc = cyc;
    end
    for (int i = 0; i < N; i++) begin
      if (busEn[i] && !prevEn[i]) begin
        check(cyc - lastFallCyc >= GAP_C + 1, "R9 enable gap", cyc - lastFallCyc, GAP_C + 1);
        enRiseCyc[i] = cyc;
        riseCnt[i] = 0;
      end
      if (busEn[i] && busClk && !prevClk) begin
        if (riseCnt[i] == 0)
          check(cyc - enRiseCyc[i] >= SETUP_C, "R5 enable setup", cyc - enRiseCyc[i], SETUP_C);
        devSh[i] = {devSh[i][6:0], busData[i]};
        riseCnt[i]++;
      end
      if (busEn[i] && prevEn[i] && (busData[i] != prevData[i]))
        check(!busClk && prevClk, "R7 data moved off falling clock", int'(busClk), 0);
      if (!busEn[i] && prevEn[i]) begin
        devCommit[i] = devSh[i];
        commitCyc[i] = cyc;
        lastFallCyc = cyc;
        check(riseCnt[i] == 8, "R2 rise count", riseCnt[i], 8);
        check(cyc - lastClkRise >= HOLD_C + 1, "R8 enable hold", cyc - lastClkRise, HOLD_C + 1);
      end
    end
    if (busEn == '0 && (busClk || busData != '0))
      check(1'b0, "R11 idle bus not quiet", int'({busClk, busData}), 0);
    prevClk = busClk;
    prevEn = busEn;
    prevData = busData;
  end

  logic [7:0] expCommit[N];

  task automatic send(input bit all, input int dev, input logic [7:0] w, input logic [8*N-1:0] lanes);
    @(negedge clk);
    reqAll = all; reqDev = 2'(dev); reqWord = w; reqLanes = lanes; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    check(busEn == '0 && (cyc - lastFallCyc) >= GAP_C, "R10 ready while busy",
          cyc - lastFallCyc, GAP_C);
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R10 ready after accept", int'(reqReady), 0);
    while (!reqReady) @(negedge clk);
  endtask

  task automatic compareAll(input string tag);
    for (int i = 0; i < N; i++)
      check(devCommit[i] == expCommit[i], tag, devCommit[i], expCommit[i]);
  endtask

  initial begin
    for (int i = 0; i < N; i++) expCommit[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busEn == '0, "R1 enables", busEn, 0);
    check(!busClk && busData == '0, "R1 clk/data", int'({busClk, busData}), 0);
    check(reqReady, "R1 ready", int'(reqReady), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // per-device sweep; non-target devices must hold their words (R3)
    for (int d = 0; d < N; d++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] w;
        case (k)
          0: w = 8'h00;
          1: w = 8'hFF;
          2: w = 8'h80;
          3: w = 8'h01;
          4: w = 8'hA5;
          5: w = 8'h5A;
          default: w = 8'(k * 8'h3B + d * 8'h11);
        endcase
        send(1'b0, d, w, {N{8'hC3}});
        expCommit[d] = w;
        check(devCommit[d] == w, "R2 target word", devCommit[d], w);
        compareAll("R3 other devices unchanged");
      end
    end

    // broadcast patterns (R4)
    for (int p = 0; p < 6; p++) begin
      logic [8*N-1:0] lanes;
      for (int i = 0; i < N; i++) begin
        lanes[8*i +: 8] = 8'(p * 8'h29 + i * 8'h47 + 1);
        expCommit[i] = lanes[8*i +: 8];
      end
      send(1'b1, p % N, 8'h00, lanes);
      compareAll("R4 lane word");
      for (int i = 1; i < N; i++)
        check(commitCyc[i] == commitCyc[0], "R4 common commit", commitCyc[i], commitCyc[0]);
    end

    // single after broadcast, then check others kept broadcast words (R3)
    send(1'b0, N - 1, 8'h6E, '0);
    expCommit[N-1] = 8'h6E;
    compareAll("R3 after broadcast");

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule